// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a small accumulator machine. A microprogram counter selects one of sixteen microinstructions held in a fixed microcode store. Each microinstruction carries a 15-bit control bundle for the datapath, a wait field, a branch field and two 4-bit target addresses. The bundle is presented on the output for as long as the counter points at that microinstruction.

Every clock the counter loads a next address. The wait field can hold the current microinstruction until the memory handshake is met. The branch field chooses one of four next-address rules: always the first target, an interrupt test, a zero test on the accumulator, or an opcode dispatch that adds the instruction opcode to the first target.

Top module: `useq_top`

## Requirements
- R1: While `rst` is high the counter is forced to 0. On the first cycle after release `upc_o` is 0 and `ctrl_o` carries the word of location 0.
- R2: `ctrl_o` bit order, bit 14 down to bit 0: mem write, mem drive, MAR load, PC load, PC drive, ACC load, ACC drive, IR load, IR drive, RET load, RET drive, ARG load, ALU select 0, ALU select 1, BUF drive. ALU select 0 is high for inc or add, and ALU select 1 is high for inc or sub.
- R3: The program, as location: transfer, ALU op, next. 0: PC→MAR, idle-wait, irq 1/2. 1: PC→RET, zero, to 12. 2: MEM→IR, ack-wait, to 3. 3: IR→MAR, idle-wait, dispatch base 4. 4: none, zero-test 5/11. 5: IR→PC, to 0. 6: ACC→ARG, idle-wait, to 13. 7: ACC→ARG, idle-wait, to 14. 8: MEM→ACC, ack-wait, to 11. 9: ACC→MEM, ack-wait, to 11. 10: RET→PC, to 0. 11: PC drive, inc, to 12. 12: BUF→PC, to 0. 13: MEM drive, add, ack-wait, to 15. 14: MEM drive, sub, ack-wait, to 15. 15: BUF→ACC, to 11.
- R4: Wait code 11 (ack-wait) holds the counter while `mem_ack` is low.
- R5: Wait code 10 (idle-wait) holds the counter while `mem_idle` is low and `mem_ack` is high.
- R6: Wait code 00 never holds, whatever the handshake inputs are.
- R7: Branch code 11 loads the first target.
- R8: Branch code 10 loads the first target when `irq_req` is high and `irq_ack` is low, and the second target otherwise.
- R9: Branch code 01 loads the first target when `acc_zero` is high, and the second target otherwise.
- R10: Branch code 00 loads the first target plus the zero-extended `opcode`, modulo 16.
- R11: At most one of the six bus-drive bits of `ctrl_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_ack | input | 1 | Memory acknowledge |
| mem_idle | input | 1 | Memory idle |
| irq_req | input | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt already acknowledged (masks requests) |
| acc_zero | input | 1 | Accumulator equals zero |
| opcode | input | 3 | Opcode of the current instruction |
| ctrl_o | output | 15 | Registered control bundle |
| upc_o | output | 4 | Registered microprogram counter |

## Verification
The bench walks the fetch path and every one of the eight opcode dispatches. It stalls each kind of wait with both handshake inputs. A design that swapped the two wait codes, or tested the wrong polarity of the acknowledge, would leave a waiting location early or stay on it too long. The interrupt branch is driven once with the request masked by `irq_ack` and once unmasked, and the zero test is driven both ways. This exposes an ungated request or swapped targets. Each visited location is compared against the expected control word, so a wrong bit order, a missing ALU select or an off-by-one dispatch shows up in the next sample.

// File: rtl/useq_pkg.sv
package useq_pkg;
  parameter int UPC_W  = 4;
  parameter int CTRL_W = 15;
  parameter int OPC_W  = 3;
  localparam int DEPTH = 1 << UPC_W;

  // control bundle bit positions (decoded by the datapath)
  localparam int B_MEM_WR  = 14;
  localparam int B_MEM_DRV = 13;
  localparam int B_MAR_LD  = 12;
  localparam int B_PC_LD   = 11;
  localparam int B_PC_DRV  = 10;
  localparam int B_ACC_LD  = 9;
  localparam int B_ACC_DRV = 8;
  localparam int B_IR_LD   = 7;
  localparam int B_IR_DRV  = 6;
  localparam int B_RET_LD  = 5;
  localparam int B_RET_DRV = 4;
  localparam int B_ARG_LD  = 3;
  localparam int B_ALU_S0  = 2;
  localparam int B_ALU_S1  = 1;
  localparam int B_BUF_DRV = 0;

  typedef enum logic [1:0] {
    WT_NONE = 2'b00, WT_RSVD = 2'b01, WT_IDLE = 2'b10, WT_ACK = 2'b11
  } wait_e;

  typedef enum logic [1:0] {
    JM_OPC = 2'b00, JM_ZERO = 2'b01, JM_IRQ = 2'b10, JM_ALWAYS = 2'b11
  } jump_e;

  typedef enum logic [2:0] {
    S_NONE, S_MEM, S_PC, S_ACC, S_IR, S_RET, S_BUF
  } src_e;

  typedef enum logic [2:0] {
    D_NONE, D_MEM, D_MAR, D_PC, D_ACC, D_IR, D_RET, D_ARG
  } dst_e;

  typedef enum logic [2:0] {
    OP_NONE, OP_ZERO, OP_INC, OP_ADD, OP_SUB
  } aluop_e;

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    wait_e             wt;
    jump_e             jm;
    logic [UPC_W-1:0]  a1;
    logic [UPC_W-1:0]  a2;
  } uword_t;

  function automatic uword_t assemble(src_e s, dst_e d, aluop_e op,
                                      wait_e wt, jump_e jm, int t1, int t2);
    uword_t w;
    w.ctrl = '0;
    case (s)
      S_MEM:   w.ctrl[B_MEM_DRV] = 1'b1;
      S_PC:    w.ctrl[B_PC_DRV]  = 1'b1;
      S_ACC:   w.ctrl[B_ACC_DRV] = 1'b1;
      S_IR:    w.ctrl[B_IR_DRV]  = 1'b1;
      S_RET:   w.ctrl[B_RET_DRV] = 1'b1;
      S_BUF:   w.ctrl[B_BUF_DRV] = 1'b1;
      default: ;
    endcase
    case (d)
      D_MEM:   w.ctrl[B_MEM_WR] = 1'b1;
      D_MAR:   w.ctrl[B_MAR_LD] = 1'b1;
      D_PC:    w.ctrl[B_PC_LD]  = 1'b1;
      D_ACC:   w.ctrl[B_ACC_LD] = 1'b1;
      D_IR:    w.ctrl[B_IR_LD]  = 1'b1;
      D_RET:   w.ctrl[B_RET_LD] = 1'b1;
      D_ARG:   w.ctrl[B_ARG_LD] = 1'b1;
      default: ;
    endcase
    w.ctrl[B_ALU_S0] = (op == OP_INC) || (op == OP_ADD);
    w.ctrl[B_ALU_S1] = (op == OP_INC) || (op == OP_SUB);
    w.wt = wt;
    w.jm = jm;
    w.a1 = UPC_W'(t1);
    w.a2 = UPC_W'(t2);
    return w;
  endfunction

  function automatic uword_t program_word(logic [UPC_W-1:0] loc);
    case (int'(loc))
      0:  return assemble(S_PC,   D_MAR,  OP_NONE, WT_IDLE, JM_IRQ,    1,  2);
      1:  return assemble(S_PC,   D_RET,  OP_ZERO, WT_NONE, JM_ALWAYS, 12, 0);
      2:  return assemble(S_MEM,  D_IR,   OP_NONE, WT_ACK,  JM_ALWAYS, 3,  0);
      3:  return assemble(S_IR,   D_MAR,  OP_NONE, WT_IDLE, JM_OPC,    4,  0);
      4:  return assemble(S_NONE, D_NONE, OP_NONE, WT_NONE, JM_ZERO,   5,  11);
      5:  return assemble(S_IR,   D_PC,   OP_NONE, WT_NONE, JM_ALWAYS, 0,  0);
      6:  return assemble(S_ACC,  D_ARG,  OP_NONE, WT_IDLE, JM_ALWAYS, 13, 0);
      7:  return assemble(S_ACC,  D_ARG,  OP_NONE, WT_IDLE, JM_ALWAYS, 14, 0);
      8:  return assemble(S_MEM,  D_ACC,  OP_NONE, WT_ACK,  JM_ALWAYS, 11, 0);
      9:  return assemble(S_ACC,  D_MEM,  OP_NONE, WT_ACK,  JM_ALWAYS, 11, 0);
      10: return assemble(S_RET,  D_PC,   OP_NONE, WT_NONE, JM_ALWAYS, 0,  0);
      11: return assemble(S_PC,   D_NONE, OP_INC,  WT_NONE, JM_ALWAYS, 12, 0);
      12: return assemble(S_BUF,  D_PC,   OP_NONE, WT_NONE, JM_ALWAYS, 0,  0);
      13: return assemble(S_MEM,  D_NONE, OP_ADD,  WT_ACK,  JM_ALWAYS, 15, 0);
      14: return assemble(S_MEM,  D_NONE, OP_SUB,  WT_ACK,  JM_ALWAYS, 15, 0);
      15: return assemble(S_BUF,  D_ACC,  OP_NONE, WT_NONE, JM_ALWAYS, 11, 0);
      default: return assemble(S_NONE, D_NONE, OP_NONE, WT_NONE, JM_ALWAYS, 0, 0);
    endcase
  endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom
  import useq_pkg::*;
(
  input  logic             clk,
  input  logic [UPC_W-1:0] addr,
  output uword_t           q
);
  // synchronous read of a constant store: maps onto a ROM-initialised block RAM
  always_ff @(posedge clk) begin
    q <= program_word(addr);
  end
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
(
  input  uword_t           cur,
  input  logic [UPC_W-1:0] upc,
  input  logic             mem_ack,
  input  logic             mem_idle,
  input  logic             irq_req,
  input  logic             irq_ack,
  input  logic             acc_zero,
  input  logic [OPC_W-1:0] opcode,
  output logic [UPC_W-1:0] nxt
);
  localparam int PAD_W = UPC_W - OPC_W;

  logic             hold;
  logic [UPC_W-1:0] opc_ext;
  logic [UPC_W-1:0] branch;

  assign opc_ext = {{PAD_W{1'b0}}, opcode};

  always_comb begin
    hold = ((cur.wt == WT_ACK)  && !mem_ack) ||
           ((cur.wt == WT_IDLE) && !mem_idle && mem_ack);
    case (cur.jm)
      JM_ALWAYS: branch = cur.a1;
      JM_IRQ:    branch = (irq_req && !irq_ack) ? cur.a1 : cur.a2;
      JM_ZERO:   branch = acc_zero ? cur.a1 : cur.a2;
      default:   branch = cur.a1 + opc_ext;
    endcase
    nxt = hold ? upc : branch;
  end
endmodule

// File: rtl/useq_top.sv
module useq_top
  import useq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              mem_ack,
  input  logic              mem_idle,
  input  logic              irq_req,
  input  logic              irq_ack,
  input  logic              acc_zero,
  input  logic [OPC_W-1:0]  opcode,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [UPC_W-1:0]  upc_o
);
  logic [UPC_W-1:0] upc_q;
  logic [UPC_W-1:0] nxt;
  logic [UPC_W-1:0] fetch_addr;
  uword_t           cur;

  // the store is read with the address the counter is about to take,
  // so cur always describes the location held in upc_q
  assign fetch_addr = rst ? '0 : nxt;

  useq_rom u_rom (
    .clk  (clk),
    .addr (fetch_addr),
    .q    (cur)
  );

  useq_next u_next (
    .cur      (cur),
    .upc      (upc_q),
    .mem_ack  (mem_ack),
    .mem_idle (mem_idle),
    .irq_req  (irq_req),
    .irq_ack  (irq_ack),
    .acc_zero (acc_zero),
    .opcode   (opcode),
    .nxt      (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) upc_q <= '0;
    else     upc_q <= nxt;
  end

  assign ctrl_o = cur.ctrl;
  assign upc_o  = upc_q;

  // R1
  reset_origin_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (upc_q == '0));

  // R4
  ack_wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cur.wt == WT_ACK && !mem_ack) |=> $stable(upc_q));

  // R5
  idle_wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cur.wt == WT_IDLE && !mem_idle && mem_ack) |=> $stable(upc_q));

  // R7
  jump_always_chk: assert property (@(posedge clk) disable iff (rst)
    (cur.wt == WT_NONE && cur.jm == JM_ALWAYS) |=> (upc_q == $past(cur.a1)));

  // R11
  single_driver_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({ctrl_o[B_MEM_DRV], ctrl_o[B_PC_DRV], ctrl_o[B_ACC_DRV],
                ctrl_o[B_IR_DRV], ctrl_o[B_RET_DRV], ctrl_o[B_BUF_DRV]}) <= 1);
endmodule

// File: tb/useq_top_tb.sv
module useq_top_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_ack = 1'b0, mem_idle = 1'b0, irq_req = 1'b0;
  logic        irq_ack = 1'b0, acc_zero = 1'b0;
  logic [2:0]  opcode = 3'd0;
  logic [14:0] ctrl_o;
  logic [3:0]  upc_o;
  int          errors = 0;
  int          checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  useq_top u_dut (
    .clk(clk), .rst(rst), .mem_ack(mem_ack), .mem_idle(mem_idle),
    .irq_req(irq_req), .irq_ack(irq_ack), .acc_zero(acc_zero),
    .opcode(opcode), .ctrl_o(ctrl_o), .upc_o(upc_o)
  );

  // expected control words from the R2 bit order and the R3 program
  function automatic logic [14:0] exp_ctrl(int loc);
    case (loc)
      0:  return 15'h1400;  1:  return 15'h0420;
      2:  return 15'h2080;  3:  return 15'h1040;
      4:  return 15'h0000;  5:  return 15'h0840;
      6:  return 15'h0108;  7:  return 15'h0108;
      8:  return 15'h2200;  9:  return 15'h4100;
      10: return 15'h0810;  11: return 15'h0406;
      12: return 15'h0801;  13: return 15'h2004;
      14: return 15'h2002;  default: return 15'h0201;
    endcase
  endfunction

  task automatic check_now(int exp, string tag);
    int drv;
    checks++;
    if (upc_o !== 4'(exp)) begin
      errors++;
      $display("FAIL %s: upc actual=%0d expected=%0d", tag, upc_o, exp);
    end
    checks++;
    if (ctrl_o !== exp_ctrl(exp)) begin
      errors++;
      $display("FAIL R2/R3 %s: ctrl actual=%h expected=%h", tag, ctrl_o, exp_ctrl(exp));
    end
    drv = ctrl_o[13] + ctrl_o[10] + ctrl_o[8] + ctrl_o[6] + ctrl_o[4] + ctrl_o[0];
    checks++;
    if (drv > 1) begin
      errors++;
      $display("FAIL R11: drivers actual=%0d expected<=1", drv);
    end
  endtask

  // set inputs at a falling edge, let one rising edge pass, sample at the next fall
  task automatic go(logic ack, logic idle, logic irq, logic iak, logic zero,
                    logic [2:0] opc, int exp, string tag);
    mem_ack = ack; mem_idle = idle; irq_req = irq; irq_ack = iak;
    acc_zero = zero; opcode = opc;
    @(negedge clk);
    check_now(exp, tag);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_now(0, "R1 reset state");
  endtask

  task automatic t_irq_entry();
    go(1, 0, 1, 0, 0, 3'd0, 0,  "R5 idle low with ack high holds");
    go(0, 0, 1, 0, 0, 3'd0, 1,  "R8 unmasked request takes first target");
    go(0, 0, 0, 0, 0, 3'd0, 12, "R6 R7 no wait, jump");
    go(1, 1, 0, 0, 0, 3'd0, 0,  "R7 back to fetch");
  endtask

  task automatic t_fetch(logic [2:0] opc, logic masked);
    go(1, 1, masked, masked, 0, opc, 2, "R8 no request or masked request");
    go(0, 1, 0, 0, 0, opc, 2, "R4 ack low holds");
    go(0, 0, 0, 0, 0, opc, 2, "R4 ack low holds again");
    go(1, 1, 0, 0, 0, opc, 3, "R7 ack high releases");
    go(1, 0, 0, 0, 0, opc, 3, "R5 idle low holds");
    go(1, 1, 0, 0, 0, opc, 4 + int'(opc), "R10 opcode dispatch");
  endtask

  task automatic t_tail11();
    go(1, 1, 0, 0, 0, 3'd0, 12, "R7 inc to 12");
    go(1, 1, 0, 0, 0, 3'd0, 0,  "R7 return to 0");
  endtask

  task automatic t_zero_taken();
    t_fetch(3'd0, 1'b1);
    go(0, 0, 0, 0, 1, 3'd0, 5, "R9 R6 zero set, no wait");
    go(1, 1, 0, 0, 0, 3'd0, 0, "R7");
  endtask

  task automatic t_zero_not_taken();
    t_fetch(3'd0, 1'b0);
    go(1, 1, 0, 0, 0, 3'd0, 11, "R9 zero clear");
    t_tail11();
  endtask

  task automatic t_jump_op();
    t_fetch(3'd1, 1'b0);
    go(1, 1, 0, 0, 0, 3'd0, 0, "R7 from 5");
  endtask

  task automatic t_add_op();
    t_fetch(3'd2, 1'b0);
    go(1, 0, 0, 0, 0, 3'd0, 6,  "R5 idle wait at 6");
    go(1, 1, 0, 0, 0, 3'd0, 13, "R7");
    go(0, 1, 0, 0, 0, 3'd0, 13, "R4 ack wait at 13");
    go(1, 1, 0, 0, 0, 3'd0, 15, "R7");
    go(1, 1, 0, 0, 0, 3'd0, 11, "R7");
    t_tail11();
  endtask

  task automatic t_sub_op();
    t_fetch(3'd3, 1'b0);
    go(1, 1, 0, 0, 0, 3'd0, 14, "R7");
    go(1, 1, 0, 0, 0, 3'd0, 15, "R7");
    go(1, 1, 0, 0, 0, 3'd0, 11, "R7");
    t_tail11();
  endtask

  task automatic t_load_store();
    t_fetch(3'd4, 1'b0);
    go(1, 1, 0, 0, 0, 3'd0, 11, "R7 load done");
    t_tail11();
    t_fetch(3'd5, 1'b0);
    go(0, 1, 0, 0, 0, 3'd0, 9,  "R4 store waits");
    go(1, 1, 0, 0, 0, 3'd0, 11, "R7 store done");
    t_tail11();
  endtask

  task automatic t_return_nop();
    t_fetch(3'd6, 1'b0);
    go(1, 1, 0, 0, 0, 3'd0, 0, "R7 return");
    t_fetch(3'd7, 1'b0);
    t_tail11();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_irq_entry();
    t_zero_taken();
    t_zero_not_taken();
    t_jump_op();
    t_add_op();
    t_sub_op();
    t_load_store();
    t_return_nop();
    t_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule